// File: doc/BRIEF.md
# ADC Result Register Bank

This block sits between an analog-to-digital converter and a CPU with an 8-bit data bus. Each finished conversion arrives as a one-cycle strobe that carries a 4-bit channel number and a 10-bit sample. The block routes the sample to one of four 16-bit result registers. The CPU can only read these registers. Each sample is stored left-aligned, with the six low bits reading as zero. An 8-bit bus cannot read a 16-bit value in one access, so the block uses a shared byte latch. Reading the upper byte of a result loads its lower byte into the latch. Reading the lower byte then returns the latch. Both bytes therefore come from the same sample, even if a new result lands between the two reads.

The block also holds the end-of-conversion flag and its interrupt enable in a status register. A small state machine controls the flag with three states:

| State | Meaning |
|---|---|
| `FLG_CLEAR` | Flag is 0. |
| `FLG_SET` | Flag is 1 but has not been seen by the CPU. |
| `FLG_ARMED` | Flag is 1 and the CPU has read it as 1. |

The transitions are:

| Transition | From | To | Cause |
|---|---|---|---|
| CLEAR→SET | `FLG_CLEAR` | `FLG_SET` | End event |
| SET→ARMED | `FLG_SET` | `FLG_ARMED` | Status read |
| ARMED→CLEAR | `FLG_ARMED` | `FLG_CLEAR` | Write of 0 to the flag |
| ARMED→SET | `FLG_ARMED` | `FLG_SET` | Any other status write |
| SET/ARMED→CLEAR | `FLG_SET` or `FLG_ARMED` | `FLG_CLEAR` | DMA read of a result |

An end event, occurring in any state, leaves the flag at 1. The interrupt request is the flag ANDed with the enable.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, every result byte reads 0x00, the status register reads 0x00 and `irq` is 0.
- R2: A result strobe stores its 10-bit sample left-aligned. Reading the upper byte (even address) returns sample[9:2]. A following lower-byte read (odd address) returns {sample[1:0], 6'b0}.
- R3: Channel 0 writes register 0, channel 1 writes register 1, channels 2 and 14 write register 2, and channels 3 and 15 write register 3. Channels 4 to 13 change no register.
- R4: A lower-byte read returns the shared latch. The latch is loaded with a register's lower byte only when that register's upper byte is read. Results that arrive later do not change it.
- R5: Writes to result addresses 0 to 7 leave every result unchanged.
- R6: Address 2*k+0 is register k's upper byte and 2*k+1 is its lower byte. Address 8 is status, with bit 7 = end flag and bit 6 = interrupt enable; other bits read 0. A status write loads bit 6 into the enable. Addresses 9 to 15 read 0.
- R7: A result strobe sets the flag when `scan_mode` is 0. When `scan_mode` is 1, it sets the flag only together with `sweep_end`.
- R8: A status write with bit 7 = 0 clears the flag only if a status read since the previous status write returned the flag as 1. Any status write consumes that read. A write of 1 to bit 7 has no effect on the flag.
- R9: A read of a result byte with `dma_rd` = 1 clears the flag.
- R10: An end event in the same cycle as a clearing write leaves the flag at 1.
- R11: `irq` equals end flag AND interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| res_valid | input | 1 | One-cycle strobe: a conversion result is present |
| res_chan | input | 4 | Channel number of the result |
| res_data | input | 10 | Conversion sample |
| scan_mode | input | 1 | 1 = scan mode, 0 = single mode |
| sweep_end | input | 1 | With a strobe in scan mode: last selected channel done |
| bus_sel | input | 1 | CPU or DMA access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| dma_rd | input | 1 | Qualifies a read as a DMA transfer |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
A wrong flag state shows up at the status byte on the next read, and at `irq` one cycle after the event while the enable is set. A stray arm or a lost arm changes the outcome of the very next clearing write. A misrouted channel or a stale latch becomes visible at the first upper-byte or lower-byte read of the affected register. Random stimulus interleaves strobes, reads, DMA reads and writes, so each such fault is exposed within a few operations of its cause.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;

    localparam int NUM_RES  = 4;
    localparam int RES_W    = 10;
    localparam int REG_W    = 16;
    localparam int BUS_W    = 8;
    localparam int ADDR_W   = 4;
    localparam int CHAN_W   = 4;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flag_state_e;

endpackage

// File: rtl/adc_chan_map.sv
module adc_chan_map #(
    parameter int CHAN_W  = 4,
    parameter int NUM_RES = 4,
    parameter int ALIAS_LO = 2
) (
    input  logic               valid,
    input  logic [CHAN_W-1:0]  chan,
    output logic [NUM_RES-1:0] wr_en
);
    localparam int ALIAS_OFS = (1 << CHAN_W) - NUM_RES;

    for (genvar i = 0; i < NUM_RES; i++) begin : g_map
        if (i >= ALIAS_LO) begin : g_alias
            assign wr_en[i] = valid &&
                ((chan == CHAN_W'(i)) || (chan == CHAN_W'(i + ALIAS_OFS)));
        end else begin : g_plain
            assign wr_en[i] = valid && (chan == CHAN_W'(i));
        end
    end

    always_comb begin
        a_r3_single_target: assert ($onehot0(wr_en));
    end

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
    parameter int NUM_RES = 4,
    parameter int RES_W   = 10,
    parameter int REG_W   = 16,
    parameter int BUS_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_RES-1:0]         wr_en,
    input  logic [RES_W-1:0]           res_data,
    input  logic                       rd_upper,
    input  logic                       rd_lower,
    input  logic [$clog2(NUM_RES)-1:0] rd_idx,
    output logic [BUS_W-1:0]           upper_byte,
    output logic [BUS_W-1:0]           lower_byte
);
    localparam int PAD_W = REG_W - RES_W;

    logic [RES_W-1:0] res_q [NUM_RES];
    logic [REG_W-1:0] full  [NUM_RES];
    logic [BUS_W-1:0] temp_q;
    logic [BUS_W-1:0] cur_lo;

    for (genvar i = 0; i < NUM_RES; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[i] <= '0;
            end else if (wr_en[i]) begin
                res_q[i] <= res_data;
            end
        end
        assign full[i] = {res_q[i], {PAD_W{1'b0}}};

        a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[i] |=> (res_q[i] == $past(res_data)));
    end

    assign cur_lo     = full[rd_idx][BUS_W-1:0];
    assign upper_byte = full[rd_idx][REG_W-1:BUS_W];
    assign lower_byte = temp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else if (rd_upper) begin
            temp_q <= cur_lo;
        end
    end

    a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        rd_upper |=> (lower_byte == $past(cur_lo)));
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_upper |=> $stable(lower_byte));
    a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lower |-> (lower_byte[PAD_W-1:0] == '0));

endmodule

// File: rtl/adc_end_flag.sv
module adc_end_flag
    import adc_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic rd_stat,
    input  logic wr_stat,
    input  logic wdata_flag,
    input  logic wdata_ie,
    input  logic dma_clr,
    output logic flag,
    output logic ie,
    output logic irq
);
    flag_state_e state_q, state_d;
    logic        ie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (wr_stat) begin
            ie_q <= wdata_ie;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (set_ev) state_d = FLG_SET;
            end
            FLG_SET: begin
                if (set_ev)       state_d = rd_stat ? FLG_ARMED : FLG_SET;
                else if (dma_clr) state_d = FLG_CLEAR;
                else if (rd_stat) state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (set_ev)       state_d = wr_stat ? FLG_SET : FLG_ARMED;
                else if (dma_clr) state_d = FLG_CLEAR;
                else if (wr_stat) state_d = wdata_flag ? FLG_SET : FLG_CLEAR;
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q != FLG_CLEAR);
        ie   = ie_q;
        irq  = flag && ie_q;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag);
    a_r8_unarmed_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_SET && wr_stat && !dma_clr) |=> flag);
    a_r8_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_ARMED && wr_stat && !wdata_flag && !set_ev) |=> !flag);
    a_r8_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> (state_q != FLG_ARMED));
    a_r9_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_clr && !set_ev) |=> !flag);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [RES_W-1:0]  res_data,
    input  logic              scan_mode,
    input  logic              sweep_end,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              dma_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int IDX_W = $clog2(NUM_RES);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2 * NUM_RES);
    localparam int FLAG_BIT = BUS_W - 1;
    localparam int IE_BIT   = BUS_W - 2;

    logic               rd_acc, wr_acc, in_res, is_stat;
    logic               rd_upper, rd_lower, rd_stat, wr_stat;
    logic               set_ev, dma_clr;
    logic [NUM_RES-1:0] wr_en;
    logic [IDX_W-1:0]   rd_idx;
    logic [BUS_W-1:0]   upper_byte, lower_byte;
    logic               flag, ie;

    assign rd_acc   = bus_sel && !bus_wr;
    assign wr_acc   = bus_sel && bus_wr;
    assign in_res   = (bus_addr < STAT_ADDR);
    assign is_stat  = (bus_addr == STAT_ADDR);
    assign rd_idx   = bus_addr[IDX_W:1];
    assign rd_upper = rd_acc && in_res && !bus_addr[0];
    assign rd_lower = rd_acc && in_res && bus_addr[0];
    assign rd_stat  = rd_acc && is_stat;
    assign wr_stat  = wr_acc && is_stat;
    assign dma_clr  = rd_acc && in_res && dma_rd;
    assign set_ev   = res_valid && (!scan_mode || sweep_end);

    adc_chan_map #(
        .CHAN_W  (CHAN_W),
        .NUM_RES (NUM_RES),
        .ALIAS_LO(2)
    ) u_map (
        .valid(res_valid),
        .chan (res_chan),
        .wr_en(wr_en)
    );

    adc_result_regs #(
        .NUM_RES(NUM_RES),
        .RES_W  (RES_W),
        .REG_W  (REG_W),
        .BUS_W  (BUS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .res_data  (res_data),
        .rd_upper  (rd_upper),
        .rd_lower  (rd_lower),
        .rd_idx    (rd_idx),
        .upper_byte(upper_byte),
        .lower_byte(lower_byte)
    );

    adc_end_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ev    (set_ev),
        .rd_stat   (rd_stat),
        .wr_stat   (wr_stat),
        .wdata_flag(bus_wdata[FLAG_BIT]),
        .wdata_ie  (bus_wdata[IE_BIT]),
        .dma_clr   (dma_clr),
        .flag      (flag),
        .ie        (ie),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_upper) begin
            bus_rdata = upper_byte;
        end else if (rd_lower) begin
            bus_rdata = lower_byte;
        end else if (rd_stat) begin
            bus_rdata[FLAG_BIT] = flag;
            bus_rdata[IE_BIT]   = ie;
        end
    end

    a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !bus_rdata[IE_BIT]) |-> !irq);
    a_r11_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !bus_rdata[FLAG_BIT]) |-> !irq);
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |-> (bus_rdata == '0));

endmodule

// File: tb/adc_result_bank_test.sv
`timescale 1ns/1ps
module adc_result_bank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_valid = 1'b0;
    logic [3:0] res_chan = '0;
    logic [9:0] res_data = '0;
    logic       scan_mode = 1'b0;
    logic       sweep_end = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       dma_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;

    logic [9:0] mreg [4];
    logic [7:0] mtemp;
    logic       mflag, marm, mie;

    always #10 clk = ~clk;

    adc_result_bank uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .scan_mode(scan_mode), .sweep_end(sweep_end),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .dma_rd(dma_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    function automatic int map_ch(input logic [3:0] ch);
        if (ch <= 4'd3) return int'(ch);
        if (ch == 4'd14) return 2;
        if (ch == 4'd15) return 3;
        return -1;
    endfunction

    task automatic cycle(input logic rv, input logic [3:0] ch, input logic [9:0] d,
                         input logic sm, input logic se, input logic sel,
                         input logic wr, input logic [3:0] a, input logic [7:0] wd,
                         input logic dm, output logic [7:0] rd);
        @(negedge clk);
        res_valid = rv; res_chan = ch; res_data = d; scan_mode = sm; sweep_end = se;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd; dma_rd = dm;
        #5;
        rd = bus_rdata;
        @(posedge clk);
        #1;
        res_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; dma_rd = 1'b0; sweep_end = 1'b0;
    endtask

    task automatic model_set();
        mflag = 1'b1;
    endtask

    task automatic do_result(input logic [3:0] ch, input logic [9:0] d,
                             input logic sm, input logic se);
        logic [7:0] rd;
        int idx;
        cycle(1'b1, ch, d, sm, se, 1'b0, 1'b0, 4'd0, 8'd0, 1'b0, rd);
        idx = map_ch(ch);
        if (idx >= 0) mreg[idx] = d;
        if (!sm || se) model_set();
    endtask

    task automatic do_read(input logic [3:0] a, input logic dm, output logic [7:0] rd);
        int k;
        cycle(1'b0, 4'd0, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, a, 8'd0, dm, rd);
        k = int'(a) / 2;
        if (a < 4'd8) begin
            if (!a[0]) mtemp = {mreg[k][1:0], 6'b0};
            if (dm) begin mflag = 1'b0; marm = 1'b0; end
        end else if (a == 4'd8) begin
            if (mflag) marm = 1'b1;
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] wd);
        logic [7:0] rd;
        cycle(1'b0, 4'd0, 10'd0, 1'b0, 1'b0, 1'b1, 1'b1, a, wd, 1'b0, rd);
        if (a == 4'd8) begin
            if (marm && !wd[7]) mflag = 1'b0;
            marm = 1'b0;
            mie = wd[6];
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a < 4'd8) return a[0] ? mtemp : mreg[int'(a) / 2][9:2];
        if (a == 4'd8) return {mflag, mie, 6'b0};
        return 8'h00;
    endfunction

    task automatic rd_check(input string tag, input logic [3:0] a, input logic dm);
        logic [7:0] e, rd;
        e = exp_read(a);
        do_read(a, dm, rd);
        check(tag, rd, e);
    endtask

    task automatic irq_check(input string tag);
        check(tag, {7'd0, irq}, {7'd0, mflag && mie});
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        for (int i = 0; i < 4; i++) mreg[i] = '0;
        mtemp = '0; mflag = 1'b0; marm = 1'b0; mie = 1'b0;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R6 unused addresses read 0
        for (int a = 0; a < 16; a++) rd_check("R1", 4'(a), 1'b0);
        irq_check("R1");

        // R2 left-aligned capture
        do_result(4'd0, 10'h3A5, 1'b0, 1'b0);
        do_read(4'd0, 1'b0, rd); check("R2", rd, 8'hE9);
        do_read(4'd1, 1'b0, rd); check("R2", rd, 8'h40);

        // R3 aliases and ignored channels
        do_result(4'd14, 10'h0FF, 1'b0, 1'b0);
        rd_check("R3", 4'd4, 1'b0);
        do_result(4'd15, 10'h2C3, 1'b0, 1'b0);
        rd_check("R3", 4'd6, 1'b0);
        rd_check("R3", 4'd7, 1'b0);
        do_result(4'd9, 10'h155, 1'b0, 1'b0);
        for (int a = 0; a < 8; a += 2) rd_check("R3", 4'(a), 1'b0);

        // R4 latch not disturbed by later result
        do_result(4'd1, 10'h003, 1'b0, 1'b0);
        rd_check("R4", 4'd2, 1'b0);
        do_result(4'd1, 10'h000, 1'b0, 1'b0);
        do_read(4'd3, 1'b0, rd); check("R4", rd, 8'hC0);

        // R5 writes to results ignored
        do_write(4'd0, 8'h12);
        do_write(4'd5, 8'hFF);
        rd_check("R5", 4'd0, 1'b0);
        rd_check("R5", 4'd5, 1'b0);

        // R8 write 0 without prior read: flag stays; write 1 after read: stays
        do_write(4'd8, 8'h00);
        rd_check("R8", 4'd8, 1'b0);
        do_write(4'd8, 8'h80);
        rd_check("R8", 4'd8, 1'b0);
        do_write(4'd8, 8'h00);
        do_read(4'd8, 1'b0, rd); check("R8", rd, 8'h00);

        // R7 scan mode needs sweep_end
        do_result(4'd2, 10'h111, 1'b1, 1'b0);
        do_read(4'd8, 1'b0, rd); check("R7", rd, 8'h00);
        do_result(4'd3, 10'h222, 1'b1, 1'b1);
        do_read(4'd8, 1'b0, rd); check("R7", rd, 8'h80);

        // R11 irq follows enable and flag
        do_write(4'd8, 8'hC0);
        irq_check("R11");
        check("R11", {7'd0, irq}, 8'h01);

        // R9 DMA read clears
        rd_check("R9", 4'd6, 1'b1);
        do_read(4'd8, 1'b0, rd); check("R9", rd, 8'h40);
        irq_check("R11");

        // R10 set wins over clearing write
        do_result(4'd0, 10'h001, 1'b0, 1'b0);
        rd_check("R10", 4'd8, 1'b0);
        cycle(1'b1, 4'd0, 10'h004, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 8'h40, 1'b0, rd);
        mreg[0] = 10'h004; marm = 1'b0; mflag = 1'b1;
        do_read(4'd8, 1'b0, rd); check("R10", rd, 8'hC0);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 7);
            case (op)
                0: do_result(4'($urandom), 10'($urandom), 1'($urandom), 1'($urandom));
                1: rd_check("R2", 4'(2 * ($urandom % 4)), 1'b0);
                2: rd_check("R4", 4'(2 * ($urandom % 4) + 1), 1'b0);
                3: rd_check("R8", 4'd8, 1'b0);
                4: do_write(4'd8, 8'($urandom));
                5: if ($urandom % 3 == 0) rd_check("R9", 4'($urandom % 8), 1'b1);
                   else rd_check("R6", 4'($urandom % 16), 1'b0);
                default: do_write(4'($urandom % 8), 8'($urandom));
            endcase
            irq_check("R11");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule